// File: doc/BRIEF.md
# CPU / DMA Shared Bus Priority Arbiter

This block decides, every clock cycle, which of two masters may use a shared memory bus: the processor or a DMA engine. The decision is combinational, so a grant appears in the same cycle as the request that earns it. When only one side asks, that side gets the bus. When both ask, the outcome follows a two-bit urgency code that travels with the DMA request, together with a flag that marks the request as a DMA port access.

Four urgency levels are supported. At level 0 the processor wins every conflict. At levels 2 and 3 the DMA wins every conflict. Level 3 is meant only for port accesses. Without the port flag it behaves as level 2. Level 1 is a fairness level. A small counter records how many conflicts in a row the DMA has lost at this level. Once that count reaches a parameterised limit (default 1), the DMA wins the next conflict, so by default it wins at least one of every two consecutive conflicts. Any cycle that is not a lost level-1 conflict clears the count.

Top module: `bus_prio_arb`

## Requirements
- R1: At most one of `cpu_gnt`/`dma_gnt` is high in any cycle. Neither is high when neither side requests, and a grant is only ever given to a side that is requesting.
- R2: When exactly one side requests, that side is granted in the same cycle, whatever the urgency code is.
- R3: With `dma_prio` = 0 and both sides requesting, `cpu_gnt` is high.
- R4: With `dma_prio` = 2 and both sides requesting, `dma_gnt` is high.
- R5: With `dma_prio` = 3, `dma_port` = 1 and both sides requesting, `dma_gnt` is high.
- R6: With `dma_prio` = 3 and `dma_port` = 0, the block acts as if `dma_prio` were 2, so in a conflict `dma_gnt` is high.
- R7: With `dma_prio` = 1, once the DMA has lost MISS_LIMIT consecutive level-1 conflicts, the next level-1 conflict is granted to the DMA. The DMA therefore never loses more than MISS_LIMIT level-1 conflicts in a row.
- R8: With `dma_prio` = 1, a conflict is granted to the CPU while the loss count is below MISS_LIMIT. The count starts at zero after reset. It returns to zero after any cycle that is not a level-1 conflict lost by the DMA, which includes a cycle where the DMA is granted, a cycle where the DMA is idle, and a conflict at another level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_req | input | 1 | Processor bus request |
| dma_req | input | 1 | DMA bus request |
| dma_prio | input | 2 | DMA urgency code: 0 low, 1 fair, 2 high, 3 top (port only) |
| dma_port | input | 1 | Marks the DMA request as a port access |
| cpu_gnt | output | 1 | Bus granted to the processor this cycle |
| dma_gnt | output | 1 | Bus granted to the DMA this cycle |

## Verification
The checker keeps its own count of consecutive level-1 losses and restarts it with the raw reset. It therefore assumes that no level-1 conflict is presented during the two cycles in which the internal reset synchroniser is still releasing. The bench holds both requests low for several cycles after reset is deasserted, so the checker and the design begin counting from the same point. Inputs change only away from the sampling edge and stay stable across it, as the combinational grant paths require. After that, the stimulus includes directed sequences followed by biased random traffic that covers all four codes and both values of the port flag.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_FAIR = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } dma_lvl_e;

  typedef struct packed {
    logic cpu;
    logic dma;
  } grant_t;
endpackage

// File: rtl/bpa_rst_sync.sv
module bpa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg[STAGES-1];
endmodule

// File: rtl/bpa_level_map.sv
module bpa_level_map
  import bpa_pkg::*;
(
  input  logic [1:0] prio_code,
  input  logic       port_acc,
  output dma_lvl_e   lvl
);
  always_comb begin
    lvl = dma_lvl_e'(prio_code);
    if (prio_code == 2'd3 && !port_acc) lvl = LVL_HIGH;
  end
endmodule

// File: rtl/bpa_loss_track.sv
module bpa_loss_track #(
  parameter int MISS_LIMIT = 1,
  localparam int CNT_W = (MISS_LIMIT < 1) ? 1 : $clog2(MISS_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loss_evt,
  output logic owed
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = loss_evt || (cnt_q != '0);
    cnt_d  = loss_evt ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign owed = (cnt_q >= CNT_W'(MISS_LIMIT));
endmodule

// File: rtl/bpa_grant_sel.sv
module bpa_grant_sel
  import bpa_pkg::*;
(
  input  logic     cpu_req,
  input  logic     dma_req,
  input  dma_lvl_e lvl,
  input  logic     owed,
  output grant_t   gnt
);
  always_comb begin
    gnt = '0;
    if (cpu_req && dma_req) begin
      unique case (lvl)
        LVL_LOW:  gnt.cpu = 1'b1;
        LVL_FAIR: begin
          gnt.dma = owed;
          gnt.cpu = !owed;
        end
        LVL_HIGH, LVL_TOP: gnt.dma = 1'b1;
        default:  gnt.cpu = 1'b1;
      endcase
    end else begin
      gnt.cpu = cpu_req;
      gnt.dma = dma_req;
    end
  end
endmodule

// File: rtl/bus_prio_arb.sv
module bus_prio_arb
  import bpa_pkg::*;
#(
  parameter int MISS_LIMIT = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       dma_req,
  input  logic [1:0] dma_prio,
  input  logic       dma_port,
  output logic       cpu_gnt,
  output logic       dma_gnt
);
  logic     rst_int_n;
  dma_lvl_e lvl;
  logic     owed;
  logic     loss_evt;
  grant_t   gnt;

  bpa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bpa_level_map u_level_map (
    .prio_code (dma_prio),
    .port_acc  (dma_port),
    .lvl       (lvl)
  );

  bpa_grant_sel u_grant_sel (
    .cpu_req (cpu_req),
    .dma_req (dma_req),
    .lvl     (lvl),
    .owed    (owed),
    .gnt     (gnt)
  );

  assign loss_evt = cpu_req && dma_req && (lvl == LVL_FAIR) && gnt.cpu;

  bpa_loss_track #(.MISS_LIMIT(MISS_LIMIT)) u_loss_track (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .loss_evt (loss_evt),
    .owed     (owed)
  );

  assign cpu_gnt = gnt.cpu;
  assign dma_gnt = gnt.dma;
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker #(
  parameter int MISS_LIMIT = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       dma_req,
  input logic [1:0] dma_prio,
  input logic       dma_port,
  input logic       cpu_gnt,
  input logic       dma_gnt
);
  logic both;
  int   lost_cnt;

  assign both = cpu_req && dma_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_cnt <= 0;
    else if (both && dma_prio == 2'd1 && cpu_gnt) lost_cnt <= lost_cnt + 1;
    else lost_cnt <= 0;
  end

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, dma_gnt}));
  // R1
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !dma_req) |-> (!cpu_gnt && !dma_gnt));
  // R1
  grant_to_asker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt |-> cpu_req) and (dma_gnt |-> dma_req));
  // R2
  lone_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !dma_req) |-> cpu_gnt);
  // R2
  lone_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !cpu_req) |-> dma_gnt);
  // R3
  low_cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && dma_prio == 2'd0) |-> cpu_gnt);
  // R4
  high_dma_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && dma_prio == 2'd2) |-> dma_gnt);
  // R5
  top_port_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && dma_prio == 2'd3 && dma_port) |-> dma_gnt);
  // R6
  top_noport_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && dma_prio == 2'd3 && !dma_port) |-> dma_gnt);
  // R7
  fair_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && dma_prio == 2'd1 && lost_cnt >= MISS_LIMIT) |-> dma_gnt);
  // R8
  fair_cpu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && dma_prio == 2'd1 && lost_cnt < MISS_LIMIT) |-> cpu_gnt);
endmodule

bind bus_prio_arb bpa_checker #(.MISS_LIMIT(MISS_LIMIT)) u_bpa_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_req  (cpu_req),
  .dma_req  (dma_req),
  .dma_prio (dma_prio),
  .dma_port (dma_port),
  .cpu_gnt  (cpu_gnt),
  .dma_gnt  (dma_gnt)
);

// File: tb/bus_prio_arb_bench.sv
`timescale 1ns/1ps
module bus_prio_arb_bench;
  localparam int LIMIT = 1;

  logic       clk;
  logic       rst_n;
  logic       cpu_req, dma_req, dma_port;
  logic [1:0] dma_prio;
  logic       cpu_gnt, dma_gnt;

  int checks = 0;
  int fails  = 0;
  int model_miss = 0;
  bit done = 0;

  bus_prio_arb #(.MISS_LIMIT(LIMIT)) u_bus_prio_arb (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
    .dma_prio(dma_prio), .dma_port(dma_port),
    .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic compare(input string tag, input bit exp_c, input bit exp_d);
    checks++;
    if (cpu_gnt !== exp_c || dma_gnt !== exp_d) begin
      fails++;
      $display("FAIL %s actual cpu_gnt=%b dma_gnt=%b expected cpu_gnt=%b dma_gnt=%b",
               tag, cpu_gnt, dma_gnt, exp_c, exp_d);
    end
  endtask

  // One cycle: drive at the falling edge, check mid-low phase, advance the model.
  task automatic step(input bit c, input bit d, input logic [1:0] p, input bit port);
    int    lvl;
    bit    ec, ed;
    string tag;
    @(negedge clk);
    cpu_req = c; dma_req = d; dma_prio = p; dma_port = port;
    #1;
    lvl = (p == 2'd3 && !port) ? 2 : int'(p);
    ec = 0; ed = 0;
    if (!c && !d)      tag = "R1";
    else if (c != d) begin tag = "R2"; ec = c; ed = d; end
    else if (lvl == 0) begin tag = "R3"; ec = 1; end
    else if (lvl == 1) begin
      if (model_miss >= LIMIT) begin tag = "R7"; ed = 1; end
      else begin tag = "R8"; ec = 1; end
    end
    else if (p == 2'd2) begin tag = "R4"; ed = 1; end
    else if (port)      begin tag = "R5"; ed = 1; end
    else                begin tag = "R6"; ed = 1; end
    compare(tag, ec, ed);
    if (c && d && lvl == 1 && ec) model_miss = model_miss + 1;
    else model_miss = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_req = 0; dma_req = 0; dma_prio = 2'd0; dma_port = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1", 0, 0);              // reset: idle, no grant
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 2'd1, 0);

    // R2: lone requesters at every code
    for (int p = 0; p < 4; p++) begin
      step(1, 0, 2'(p), 1);
      step(0, 1, 2'(p), 0);
    end
    // R3..R6: fixed levels in conflict
    step(1, 1, 2'd0, 1);
    step(1, 1, 2'd2, 0);
    step(1, 1, 2'd3, 1);
    step(1, 1, 2'd3, 0);
    // R8 then R7: alternation under fair level, first conflict after reset to CPU
    for (int i = 0; i < 6; i++) step(1, 1, 2'd1, 0);
    // R8: DMA idle clears the count
    step(1, 1, 2'd1, 0);
    step(1, 0, 2'd1, 0);
    step(1, 1, 2'd1, 0);
    // R8: DMA uncontested win clears the count
    step(0, 1, 2'd1, 0);
    step(1, 1, 2'd1, 0);
    // R8: conflict at another level clears the count
    step(0, 0, 2'd0, 0);
    step(1, 1, 2'd1, 0);
    step(1, 1, 2'd0, 0);
    step(1, 1, 2'd1, 0);
    step(1, 1, 2'd1, 0);

    // biased random traffic
    for (int i = 0; i < 4000; i++) begin
      bit c, d;
      logic [1:0] p;
      c = ($urandom_range(0, 3) != 0);
      d = ($urandom_range(0, 3) != 0);
      p = ($urandom_range(0, 1) == 0) ? 2'd1 : 2'($urandom_range(0, 3));
      step(c, d, p, 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule